// File: doc/BRIEF.md
# Alternate-Space Double-Float Load Exception Classifier

This block decides which exception a double-precision floating-point alternate-space load must raise when it names a space identifier reserved for store-only use. Two groups of identifiers count as reserved: the block-store-with-commit spaces and the partial-store spaces. A load that names either group is illegal. The block ranks the possible exceptions by the alignment of the low address bits. A badly aligned address raises one of two misaligned-address exceptions. A correctly aligned address raises a data access fault, and that fault reports the "invalid space identifier" fault type.

The pipeline stage samples one request per clock: a valid strobe, the 8-bit space identifier, the three low address bits and the destination register number. One cycle later it presents a one-hot exception vector and a 3-bit fault-type code. A request in any other space comes out flagged as passing through legally. The destination register number never changes the outcome.

Top module: `asi_ldd_exc_classify`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `exc_onehot`, `fault_code` and `pass_legal` are all zero.
- R2: Space identifiers 0xE0 and 0xE1 are reserved (store-only commit spaces). 0xE2 through 0xEF are not reserved.
- R3: Space identifiers 0xC0 to 0xC5 and 0xC8 to 0xCD are reserved (partial-store spaces). 0xC6, 0xC7, 0xCE and 0xCF are not reserved.
- R4: For a valid request in a reserved space with `addr_lo[1:0]` not equal to zero, `exc_onehot` = 3'b001 (general misaligned address).
- R5: For a valid request in a reserved space with `addr_lo[1:0]` = 0 and `addr_lo[2]` = 1, `exc_onehot` = 3'b010 (double-float load misaligned).
- R6: For a valid request in a reserved space with `addr_lo[2:0]` = 0, `exc_onehot` = 3'b100 (data access fault) and `fault_code` = 3'b011 (invalid space identifier).
- R7: `fault_code` is zero whenever `exc_onehot[2]` is zero.
- R8: The value of `rd` has no effect on any output.
- R9: A valid request in a reserved space sets exactly one bit of `exc_onehot` and keeps `pass_legal` low. A valid request in any other space sets `pass_legal` and leaves `exc_onehot` zero.
- R10: When `req_vld` is low, every output is zero in the following cycle.
- R11: Outputs reflect the request sampled at the previous rising edge (one-cycle latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Load request strobe |
| space_id | input | 8 | Alternate space identifier |
| addr_lo | input | 3 | Low address bits |
| rd | input | RD_W | Destination register number |
| exc_onehot | output | 3 | {data access, double-float misaligned, general misaligned} |
| fault_code | output | 3 | Fault type code; 3'b011 means invalid space identifier |
| pass_legal | output | 1 | Valid request outside the reserved spaces |

## Verification
Three properties are checked by the assertions on every cycle, using the request registered one edge earlier:
- at most one exception bit is set;
- the fault code is nonzero exactly when the data access bit is set;
- an exception and a legal pass never appear together, and each valid request yields one of the two.

Some behaviour can only be shown by the bench's sweep, which covers every identifier, every low-address pattern and several register numbers. That includes:
- the exact membership of the reserved identifier ranges;
- which exception each alignment selects;
- the fault code value;
- the fact that `rd` is ignored.

// File: rtl/asi_ldd_exc_classify.sv
module asi_ldd_exc_classify #(
  parameter int RD_W = 5,
  parameter logic [2:0] FT_BAD_SPACE = 3'b011
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_vld,
  input  logic [7:0]      space_id,
  input  logic [2:0]      addr_lo,
  input  logic [RD_W-1:0] rd,
  output logic [2:0]      exc_onehot,
  output logic [2:0]      fault_code,
  output logic            pass_legal
);

  logic commit_sp, partial_sp, reserved;
  logic mis_gen, mis_ldd, dax;
  logic rd_unused;

  assign rd_unused  = ^rd;
  assign commit_sp  = (space_id[7:1] == 7'b1110_000);
  assign partial_sp = (space_id[7:4] == 4'hC) && (space_id[2:1] != 2'b11);
  assign reserved   = commit_sp | partial_sp;

  assign mis_gen = (addr_lo[1:0] != 2'b00);
  assign mis_ldd = !mis_gen && addr_lo[2];
  assign dax     = !mis_gen && !addr_lo[2];

  always_ff @(posedge clk) begin
    if (rst) begin
      exc_onehot <= '0;
      fault_code <= '0;
      pass_legal <= 1'b0;
    end else begin
      exc_onehot <= (req_vld && reserved) ? {dax, mis_ldd, mis_gen} : 3'b000;
      fault_code <= (req_vld && reserved && dax) ? FT_BAD_SPACE : 3'b000;
      pass_legal <= req_vld && !reserved;
    end
  end

  logic past_ok, vld_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      past_ok <= 1'b1;
      vld_q   <= req_vld;
    end
  end

  a_r9_onehot_exc: assert property (@(posedge clk) disable iff (rst)
    $onehot0(exc_onehot));

  a_r9_exc_pass_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(pass_legal && (exc_onehot != 3'b000)));

  a_r7_code_tracks_dax: assert property (@(posedge clk) disable iff (rst)
    ((fault_code != 3'b000) == exc_onehot[2]));

  a_r11_valid_gives_result: assert property (@(posedge clk) disable iff (rst)
    past_ok && vld_q |-> (pass_legal || $countones(exc_onehot) == 1));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    past_ok && !vld_q |-> (exc_onehot == 3'b000 && !pass_legal && fault_code == 3'b000));

endmodule

// File: tb/asi_ldd_exc_classify_tb.sv
module asi_ldd_exc_classify_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_vld = 1'b0;
  logic [7:0] space_id = '0;
  logic [2:0] addr_lo = '0;
  logic [4:0] rd = '0;
  logic [2:0] exc_onehot, fault_code;
  logic pass_legal;
  int vectors = 0;
  int errors = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  asi_ldd_exc_classify #(.RD_W(5)) dut_i (
    .clk(clk), .rst(rst), .req_vld(req_vld), .space_id(space_id),
    .addr_lo(addr_lo), .rd(rd), .exc_onehot(exc_onehot),
    .fault_code(fault_code), .pass_legal(pass_legal)
  );

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual cycles=%0d expected below 150000", cycles);
      finish_run();
    end
  end

  task automatic cmp(input string tag, input logic [6:0] act, input logic [6:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual {exc,code,pass}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [7:0] sid, input logic [2:0] a, input logic [4:0] r);
    logic res;
    logic [2:0] e, c;
    logic p;
    string tag;
    req_vld = v; space_id = sid; addr_lo = a; rd = r;
    @(negedge clk);
    res = (sid == 8'hE0) || (sid == 8'hE1) ||
          (sid >= 8'hC0 && sid <= 8'hC5) || (sid >= 8'hC8 && sid <= 8'hCD);
    e = 3'b000; c = 3'b000; p = 1'b0;
    if (v && res) begin
      if (a % 4 != 0) e = 3'b001;
      else if (a == 3'd4) e = 3'b010;
      else begin e = 3'b100; c = 3'b011; end
    end
    p = v && !res;
    if (!v) tag = "R10";
    else if (r != 0) tag = "R8";
    else if (!res) tag = (sid[7:4] == 4'hE) ? "R2/R9" : "R3/R9";
    else if (e == 3'b001) tag = "R4/R11";
    else if (e == 3'b010) tag = "R5/R11";
    else tag = "R6/R7";
    cmp(tag, {exc_onehot, fault_code, pass_legal}, {e, c, p});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cmp("R1 in reset", {exc_onehot, fault_code, pass_legal}, 7'b0);
    rst = 1'b0;
    @(negedge clk);
    cmp("R1 after reset", {exc_onehot, fault_code, pass_legal}, 7'b0);
    for (int s = 0; s < 256; s++)
      for (int a = 0; a < 8; a++) begin
        apply(1'b1, 8'(s), 3'(a), 5'd0);
        apply(1'b1, 8'(s), 3'(a), 5'd31);
        apply(1'b1, 8'(s), 3'(a), 5'(s + a));
        apply(1'b0, 8'(s), 3'(a), 5'd7);
      end
    apply(1'b1, 8'hE1, 3'd0, 5'd3);
    apply(1'b1, 8'hCD, 3'd4, 5'd3);
    apply(1'b1, 8'hC6, 3'd0, 5'd0);
    finish_run();
  end
endmodule